// File: doc/BRIEF.md
# Serial DAC Command Receiver

This block is the digital front end of a voltage-output DAC. It listens on a three-wire slave bus: an active-low select, a serial clock and a serial data line. Each select frame carries exactly one 16-bit word, sent most significant bit first. The top four bits form a command code and the lower twelve carry the payload. The bus pins are brought into the system clock domain through a two-flop synchroniser. Edge detection then finds the falling edges of the serial clock, and the data line is sampled on those edges.

An internal counter counts the falling edges. On the sixteenth edge the assembled word is latched and its command is decoded at once. Any further edges are ignored until select has gone high again. A load command copies the data field into the held DAC code and emits a one-cycle update strobe. A power command takes its two lowest bits as the output-state selection. Every other command is dropped. The DAC resolution is a parameter of 12, 10 or 8 bits. At 12 bits the code uses the low twelve bits. At 10 or 8 bits the code sits just above the two low bits, and those two bits serve only as the power field.

Top module: `dac_cmd_rx`

## Requirements
- R1: Reset sets the held code to zero and the output state to 00 (active), and no update strobe is produced while reset is held.
- R2: A complete 16-bit frame (MSB first, sampled on serial clock falling edges while select is low) whose top nibble is 0000 loads the data field into the held code. At the default 12-bit resolution the data field is word bits [11:0].
- R3: A complete frame whose top nibble is 1111 sets the output state to word bits [1:0]: 00 active, 01 floating, 10 low-ohm termination, 11 high-ohm termination. The held code is not changed and no strobe is produced.
- R4: If select rises before the 16th falling edge, the partial word is discarded, and the code, the output state and the strobe are all unaffected.
- R5: Falling edges after the 16th in a frame are ignored until select goes high. The next frame after select has toggled is accepted normally.
- R6: Command nibbles other than 0000 and 1111 leave the code and the output state unchanged and produce no strobe.
- R7: Serial clock edges while select is high shift nothing, and the following frame decodes exactly as sent.
- R8: Each accepted load produces exactly one update strobe, one system clock cycle wide, in the same cycle that the new code appears. The code never changes without a strobe.
- R9: For a resolution N below 12, the held code is taken from word bits [N+1:2].
- R10: A power command with bits [1:0] = 00 returns a powered-down output to the active state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Bus select, active low, asynchronous to clk |
| sclk_i | input | 1 | Bus serial clock, asynchronous to clk |
| sdi_i | input | 1 | Bus serial data |
| dac_code_o | output | DAC_BITS | Held DAC code (second buffer stage) |
| dac_upd_o | output | 1 | One-cycle strobe marking a code update |
| out_mode_o | output | 2 | Output state: 00 active, 01 float, 10 low-ohm, 11 high-ohm |

## Verification
A corrupted bit counter or lock flag appears at the ports within one frame. The next word then decodes shifted by one or more bits, so the held code or output state differs from what was sent. A frame that should have been rejected or ignored shows up as a spurious strobe about five system cycles after the last serial edge. A stuck strobe or a code that changes without a strobe breaks the strobe-versus-code relation in the very cycle it happens. Each frame is therefore followed by a comparison of the code, the output state and the number of strobes.

// File: rtl/dacrx_pkg.sv
package dacrx_pkg;
    localparam int WORD_BITS = 16;
    localparam int CTRL_BITS = 4;
    localparam int PAYLOAD_BITS = WORD_BITS - CTRL_BITS;
    localparam int PWR_BITS = 2;

    localparam logic [CTRL_BITS-1:0] CMD_LOAD = 4'h0;
    localparam logic [CTRL_BITS-1:0] CMD_PWR  = 4'hF;

    typedef enum logic [PWR_BITS-1:0] {
        MODE_ACTIVE    = 2'b00,
        MODE_FLOAT     = 2'b01,
        MODE_TERM_LOW  = 2'b10,
        MODE_TERM_HIGH = 2'b11
    } out_mode_e;
endpackage

// File: rtl/dacrx_sync.sv
module dacrx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pipe <= {STAGES{RESET_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.pipe[STAGES-1];
endmodule

// File: rtl/dacrx_shifter.sv
module dacrx_shifter
    import dacrx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n_s,
    input  logic                 sclk_s,
    input  logic                 sdi_s,
    output logic                 word_vld_o,
    output logic [WORD_BITS-1:0] word_o
);
    localparam int CNT_W = $clog2(WORD_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_BITS - 1);

    typedef struct packed {
        logic                 sclk_prev;
        logic [WORD_BITS-1:0] shreg;
        logic [CNT_W-1:0]     cnt;
        logic                 locked;
        logic                 vld;
        logic [WORD_BITS-1:0] word;
    } shift_state_t;

    shift_state_t st_d, st_q;
    logic fall;
    logic [WORD_BITS-1:0] shifted;

    always_comb begin
        st_d = st_q;
        st_d.vld = 1'b0;
        st_d.sclk_prev = sclk_s;
        fall = st_q.sclk_prev & ~sclk_s;
        shifted = {st_q.shreg[WORD_BITS-2:0], sdi_s};

        if (cs_n_s) begin
            st_d.cnt = '0;
            st_d.locked = 1'b0;
        end else if (fall && !st_q.locked) begin
            st_d.shreg = shifted;
            if (st_q.cnt == LAST_CNT) begin
                st_d.cnt = '0;
                st_d.locked = 1'b1;
                st_d.vld = 1'b1;
                st_d.word = shifted;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_vld_o = st_q.vld;
    assign word_o = st_q.word;
endmodule

// File: rtl/dacrx_decode.sv
module dacrx_decode
    import dacrx_pkg::*;
#(
    parameter int DAC_BITS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 word_vld_i,
    input  logic [WORD_BITS-1:0] word_i,
    output logic [DAC_BITS-1:0]  code_o,
    output logic                 upd_o,
    output out_mode_e            mode_o
);
    typedef struct packed {
        logic [DAC_BITS-1:0] code;
        logic                upd;
        out_mode_e           mode;
    } dec_state_t;

    dec_state_t st_d, st_q;
    logic [DAC_BITS-1:0]  data_field;
    logic [CTRL_BITS-1:0] cmd;

    assign cmd = word_i[WORD_BITS-1 -: CTRL_BITS];

    generate
        if (DAC_BITS == PAYLOAD_BITS) begin : g_full
            assign data_field = word_i[DAC_BITS-1:0];
        end else begin : g_above_pwr
            assign data_field = word_i[DAC_BITS+PWR_BITS-1:PWR_BITS];
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        st_d.upd = 1'b0;
        if (word_vld_i) begin
            if (cmd == CMD_LOAD) begin
                st_d.code = data_field;
                st_d.upd = 1'b1;
            end else if (cmd == CMD_PWR) begin
                st_d.mode = out_mode_e'(word_i[PWR_BITS-1:0]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.code <= '0;
            st_q.upd <= 1'b0;
            st_q.mode <= MODE_ACTIVE;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.code;
    assign upd_o = st_q.upd;
    assign mode_o = st_q.mode;
endmodule

// File: rtl/dac_cmd_rx.sv
module dac_cmd_rx
    import dacrx_pkg::*;
#(
    parameter int DAC_BITS    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n_i,
    input  logic                sclk_i,
    input  logic                sdi_i,
    output logic [DAC_BITS-1:0] dac_code_o,
    output logic                dac_upd_o,
    output logic [1:0]          out_mode_o
);
    logic [2:0] bus_s;
    logic word_vld;
    logic [WORD_BITS-1:0] word;
    out_mode_e mode;

    dacrx_sync #(
        .WIDTH    (3),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(3'b100)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({cs_n_i, sclk_i, sdi_i}),
        .sync_o (bus_s)
    );

    dacrx_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (bus_s[2]),
        .sclk_s    (bus_s[1]),
        .sdi_s     (bus_s[0]),
        .word_vld_o(word_vld),
        .word_o    (word)
    );

    dacrx_decode #(
        .DAC_BITS(DAC_BITS)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_vld_i(word_vld),
        .word_i    (word),
        .code_o    (dac_code_o),
        .upd_o     (dac_upd_o),
        .mode_o    (mode)
    );

    assign out_mode_o = mode;
endmodule

// File: rtl/dacrx_checker.sv
module dacrx_checker #(
    parameter int DAC_BITS = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cs_n_i,
    input logic [DAC_BITS-1:0] dac_code_o,
    input logic                dac_upd_o,
    input logic [1:0]          out_mode_o
);
    // R8: strobe lasts a single cycle
    p_upd_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dac_upd_o |=> !dac_upd_o);

    // R8: the code only moves together with a strobe
    p_code_needs_upd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_upd_o |-> $stable(dac_code_o));

    // R3: a load never alters the output state
    p_load_keeps_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dac_upd_o |-> $stable(out_mode_o));

    // R7: a long idle select gives no strobe, whatever the serial clock does
    p_idle_no_upd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i && $past(cs_n_i, 1) && $past(cs_n_i, 2) && $past(cs_n_i, 3)
         && $past(cs_n_i, 4) && $past(cs_n_i, 5) && $past(cs_n_i, 6)
         && $past(cs_n_i, 7) && $past(cs_n_i, 8)) |-> !dac_upd_o);

    // R1: reset values
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_vals_r1: assert (dac_code_o == '0 && out_mode_o == 2'b00 && !dac_upd_o);
        end
    end
endmodule

bind dac_cmd_rx dacrx_checker #(.DAC_BITS(DAC_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_i    (cs_n_i),
    .dac_code_o(dac_code_o),
    .dac_upd_o (dac_upd_o),
    .out_mode_o(out_mode_o)
);

// File: tb/tb_dac_cmd_rx.sv
module tb_dac_cmd_rx;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT = 4;
    localparam int NVEC = 12;

    // {bits sent(5), extra edges(4), word(16), exp code(12), exp mode(2), exp strobes(2)}
    localparam logic [40:0] VEC [NVEC] = '{
        {5'd16, 4'd0, 16'h0ABC, 12'hABC, 2'd0, 2'd1},  // R2
        {5'd16, 4'd0, 16'hF001, 12'hABC, 2'd1, 2'd0},  // R3
        {5'd16, 4'd0, 16'hF002, 12'hABC, 2'd2, 2'd0},  // R3
        {5'd16, 4'd0, 16'hF003, 12'hABC, 2'd3, 2'd0},  // R3
        {5'd16, 4'd0, 16'hF000, 12'hABC, 2'd0, 2'd0},  // R10
        {5'd10, 4'd0, 16'h0123, 12'hABC, 2'd0, 2'd0},  // R4
        {5'd16, 4'd0, 16'h5555, 12'hABC, 2'd0, 2'd0},  // R6
        {5'd16, 4'd0, 16'h0FFF, 12'hFFF, 2'd0, 2'd1},  // R2
        {5'd15, 4'd0, 16'hF001, 12'hFFF, 2'd0, 2'd0},  // R4
        {5'd16, 4'd0, 16'h0000, 12'h000, 2'd0, 2'd1},  // R2
        {5'd16, 4'd5, 16'h0C3A, 12'hC3A, 2'd0, 2'd1},  // R5
        {5'd16, 4'd0, 16'h8F01, 12'hC3A, 2'd0, 2'd0}   // R6
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic [11:0] code;
    logic        upd;
    logic [1:0]  mode;
    logic [7:0]  code8;
    logic        upd8;
    logic [1:0]  mode8;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int run_len = 0;
    int max_run = 0;
    logic [7:0] exp8 = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_cmd_rx #(.DAC_BITS(12)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
        .dac_code_o(code), .dac_upd_o(upd), .out_mode_o(mode)
    );

    dac_cmd_rx #(.DAC_BITS(8)) dut_n8 (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
        .dac_code_o(code8), .dac_upd_o(upd8), .out_mode_o(mode8)
    );

    always @(negedge clk) begin
        if (upd) begin
            pulses++;
            run_len++;
            if (run_len > max_run) max_run = run_len;
        end else begin
            run_len = 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_bit(input logic b);
        sdi = b;
        sclk = 1'b1;
        wait_clk(HALF_BIT);
        sclk = 1'b0;
        wait_clk(HALF_BIT);
    endtask

    task automatic send(input logic [15:0] w, input int nbits, input int extra);
        cs_n = 1'b0;
        wait_clk(HALF_BIT);
        for (int i = 0; i < nbits; i++) bus_bit(w[15-i]);
        for (int i = 0; i < extra; i++) bus_bit(1'b1);
        wait_clk(HALF_BIT);
        cs_n = 1'b1;
        wait_clk(12);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        wait_clk(3);
        check(code == 12'h000, "R1 code", code, 0);
        check(mode == 2'b00, "R1 mode", mode, 0);
        check(upd == 1'b0 && pulses == 0, "R1 strobe", pulses, 0);
        rst_n = 1'b1;
        wait_clk(4);

        for (int v = 0; v < NVEC; v++) begin
            automatic logic [40:0] e = VEC[v];
            automatic int nb = int'(e[40:36]);
            automatic int ex = int'(e[35:32]);
            automatic logic [15:0] w = e[31:16];
            automatic int p0 = pulses;
            send(w, nb, ex);
            if (nb == 16 && w[15:12] == 4'h0) exp8 = w[9:2];
            check(code == e[15:4], $sformatf("R2/R3/R4/R5/R6 code vec %0d", v), code, int'(e[15:4]));
            check(mode == e[3:2], $sformatf("R3/R10 mode vec %0d", v), mode, int'(e[3:2]));
            check(pulses - p0 == int'(e[1:0]), $sformatf("R8 strobe count vec %0d", v), pulses - p0, int'(e[1:0]));
            check(code8 == exp8, $sformatf("R9 narrow code vec %0d", v), code8, exp8);
        end

        // R5: after extra edges and a select toggle, the next word is accepted
        send(16'h0456, 16, 0);
        check(code == 12'h456, "R5 next frame", code, 12'h456);

        // R7: serial clock toggling with select high shifts nothing
        for (int i = 0; i < 7; i++) bus_bit(1'b1);
        wait_clk(12);
        check(code == 12'h456, "R7 idle clocks no load", code, 12'h456);
        send(16'h0321, 16, 0);
        check(code == 12'h321, "R7 clean frame after idle clocks", code, 12'h321);
        exp8 = 8'hC8;
        check(code8 == exp8, "R9 narrow code 0321", code8, exp8);

        // R10: wake from high-ohm termination
        send(16'hF003, 16, 0);
        check(mode == 2'b11, "R3 term high", mode, 3);
        send(16'hF000, 16, 0);
        check(mode == 2'b00, "R10 wake", mode, 0);

        check(max_run == 1, "R8 strobe width", max_run, 1);

        // R1: reset in mid-run
        send(16'hF002, 16, 0);
        rst_n = 1'b0;
        wait_clk(2);
        check(code == 12'h000, "R1 code after reset", code, 0);
        check(mode == 2'b00, "R1 mode after reset", mode, 0);
        rst_n = 1'b1;
        wait_clk(4);

        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule